// File: doc/BRIEF.md
# Rotating-Frame PI Voltage Regulator

This block closes the output-voltage loop of a three-phase, three-level inverter without measuring either DC-link capacitor. On each sample strobe it takes three per-unit phase voltage samples. It projects them onto a rotating d/q frame and a zero-sequence axis, using an angle produced by an internal phase accumulator at the fundamental frequency. Each projected component is compared with its setpoint. The error drives a discrete PI controller whose integrator is held inside a configurable band.

The three controller outputs are rotated back into three phase references for the carrier-based modulator. The block also reports the magnitude of the d/q command vector as a modulation index. A single shared multiplier does all the products. A small step sequencer drives it, and a bit-serial square-root unit finishes the magnitude. All outputs change together in the one cycle where a completion pulse is raised.

Top module: `dq0_pi_regulator`

## Requirements
- R1: After reset, all four result outputs read 0 and `done` is low. The integrators and the phase accumulator are cleared, so the first sample after reset uses angle 0 and has no integral contribution.
- R2: Each sample uses the current accumulator value, and the accumulator then advances by round(F0·2^32/FS) (21474836 for 50 Hz at 10 kHz). Phase b uses the accumulator minus 1431655765, phase c uses it minus 2·1431655765, and every cosine adds 2^30 to the sine angle.
- R3: The angle is taken from the top 10 accumulator bits (k = 0..1023). The sine value is round(32767·sin(2πk/1024)), served from a quarter-wave table.
- R4: The measured components are vd = 2/3·Σ vx·sin(θ−φx), vq = 2/3·Σ vx·cos(θ−φx) and v0 = (va+vb+vc)/3, with φ = 0°, 120°, 240°. All values are Q1.15 and saturate to [−1, 32767/32768].
- R5: For each axis, e = setpoint − measured (saturated) and u = sat(Kp·e + I). The integrator I is updated to I + KiTs·e only after u is formed. Defaults are Kp = 3277/32768 and KiTs = 33/32768.
- R6: The integrator stays within ±INT_LIM, which defaults to 16384/32768 = 0.5.
- R7: The phase references are ref_x = sat(ud·sin(θ−φx) + uq·cos(θ−φx) + u0). A reference whose exact value exceeds 1 reads exactly 32767.
- R8: mod_index = floor(sqrt(ud² + uq²)) in Q1.15, capped at 32767.
- R9: `done` is a one-cycle pulse between 20 and 64 cycles after an accepted strobe. The outputs and the accumulator change only in the cycle where `done` is high.
- R10: A strobe that arrives while a computation is in progress is ignored. It produces no extra `done` and no extra accumulator step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Starts one regulation step when the block is idle |
| ph_a | input | 16 | Phase a voltage sample, Q1.15 |
| ph_b | input | 16 | Phase b voltage sample, Q1.15 |
| ph_c | input | 16 | Phase c voltage sample, Q1.15 |
| set_d | input | 16 | d-axis setpoint, Q1.15 |
| set_q | input | 16 | q-axis setpoint, Q1.15 |
| set_z | input | 16 | Zero-sequence setpoint, Q1.15 |
| ref_a | output | 16 | Phase a modulator reference, Q1.15 |
| ref_b | output | 16 | Phase b modulator reference, Q1.15 |
| ref_c | output | 16 | Phase c modulator reference, Q1.15 |
| mod_index | output | 16 | Modulation index, Q1.15 |
| done | output | 1 | One-cycle pulse when the outputs update |

## Verification
The assertions check several invariants on every cycle:
- `done` is a single-cycle pulse.
- The outputs and the phase accumulator stay frozen outside that pulse.
- The latched samples stay put when a strobe arrives mid-computation.
- Every integrator stays inside its band.
- Each square root is the exact floor root of its radicand.

The numeric behaviour needs the bench scenarios. These cover the transform and table accuracy across many angles, the PI ordering and the integral build-up into the clamp, saturation of a reference, and the absence of a second step after a doubled strobe. They are checked against a real-valued model.

// File: rtl/dq0_reg_pkg.sv
package dq0_reg_pkg;
  typedef logic signed [15:0] q15_t;

  localparam int Q_FRAC = 15;
  localparam int OP_W   = 18;            // shared multiplier operand width
  localparam int PR_W   = 2 * OP_W;      // product width
  localparam int AC_W   = 40;            // accumulator width
  localparam logic signed [OP_W-1:0] K_TWO_THIRDS = 18'sd21845;
  localparam logic signed [OP_W-1:0] K_ONE_THIRD  = 18'sd10923;

  // saturate a wide value into Q1.15
  function automatic q15_t sat_q15(input logic signed [AC_W-1:0] x);
    if (x > 40'sd32767)  return 16'sh7fff;
    if (x < -40'sd32768) return 16'sh8000;
    return x[15:0];
  endfunction

  // drop 15 fraction bits with round-half-up
  function automatic logic signed [AC_W-1:0] rnd_q15(input logic signed [AC_W-1:0] x);
    return (x + 40'sd16384) >>> Q_FRAC;
  endfunction

  // elaboration-time sine table entry, odd Taylor series up to x^17
  function automatic int sine_entry(input int k, input int quarter);
    real x, term, sum;
    x = 1.5707963267948966 * real'(k) / real'(quarter);
    term = x;
    sum  = x;
    for (int n = 1; n < 9; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return $rtoi(sum * 32767.0 + 0.5);
  endfunction
endpackage

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut
  import dq0_reg_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx,
  output q15_t             val
);
  localparam int QTR = 1 << (IDX_W - 2);
  localparam int AW  = IDX_W - 1;

  q15_t rom [0:QTR];
  for (genvar k = 0; k <= QTR; k++) begin : g_rom
    localparam int ENTRY = sine_entry(k, QTR);
    assign rom[k] = q15_t'(ENTRY);
  end

  logic             mirror, negate;
  logic [IDX_W-3:0] fine;
  logic [AW-1:0]    addr;

  assign mirror = idx[IDX_W-2];
  assign negate = idx[IDX_W-1];
  assign fine   = idx[IDX_W-3:0];
  assign addr   = mirror ? (AW'(QTR) - AW'(fine)) : AW'(fine);
  assign val    = negate ? -rom[addr] : rom[addr];
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int              PH_W = 32,
  parameter logic [PH_W-1:0] STEP = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [PH_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (adv) phase <= phase + STEP;
  end
endmodule

// File: rtl/isqrt_seq.sv
module isqrt_seq #(
  parameter int RAD_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RAD_W-1:0]   rad,
  output logic               done,
  output logic [RAD_W/2-1:0] root
);
  localparam int ROOT_W = RAD_W / 2;
  localparam int CNT_W  = $clog2(ROOT_W + 1);

  logic [RAD_W-1:0] rem_q, res_q, bit_q, rad_q, trial;
  logic [CNT_W-1:0] cnt;
  logic             run, fits;

  assign trial = res_q + bit_q;
  assign fits  = rem_q >= trial;
  assign root  = res_q[ROOT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0; res_q <= '0; bit_q <= '0; rad_q <= '0;
      cnt <= '0; run <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= rad;
        rad_q <= rad;
        res_q <= '0;
        bit_q <= RAD_W'(1) << (RAD_W - 2);
        cnt   <= CNT_W'(ROOT_W);
        run   <= 1'b1;
      end else if (run) begin
        if (fits) begin
          rem_q <= rem_q - trial;
          res_q <= (res_q >> 1) + bit_q;
        end else begin
          res_q <= res_q >> 1;
        end
        bit_q <= bit_q >> 2;
        cnt   <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R8
  root_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (64'(root) * 64'(root) <= 64'(rad_q)) &&
             ((64'(root) + 64'd1) * (64'(root) + 64'd1) > 64'(rad_q)));
endmodule

// File: rtl/dq0_pi_regulator.sv
module dq0_pi_regulator
  import dq0_reg_pkg::*;
#(
  parameter int F0_HZ       = 50,
  parameter int FS_HZ       = 10000,
  parameter int PH_W        = 32,
  parameter int LUT_IDX_W   = 10,
  parameter int KP_Q15      = 3277,
  parameter int KITS_Q15    = 33,
  parameter int INT_LIM_Q15 = 16384
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_stb,
  input  logic signed [15:0] ph_a,
  input  logic signed [15:0] ph_b,
  input  logic signed [15:0] ph_c,
  input  logic signed [15:0] set_d,
  input  logic signed [15:0] set_q,
  input  logic signed [15:0] set_z,
  output logic signed [15:0] ref_a,
  output logic signed [15:0] ref_b,
  output logic signed [15:0] ref_c,
  output logic signed [15:0] mod_index,
  output logic               done
);
  localparam logic [PH_W-1:0] PH_STEP =
    PH_W'(((64'(F0_HZ) << PH_W) + 64'(FS_HZ / 2)) / 64'(FS_HZ));
  localparam logic [PH_W-1:0] PH_THIRD = PH_W'(((64'd1 << PH_W) + 64'd1) / 64'd3);
  localparam logic [PH_W-1:0] PH_QTR   = PH_W'(64'd1 << (PH_W - 2));
  localparam int IW     = 32;
  localparam int STEP_W = 5;
  localparam int S_SQRT = 22;
  localparam int S_WAIT = 23;
  localparam logic signed [AC_W-1:0] I_LIM = AC_W'(INT_LIM_Q15) <<< Q_FRAC;
  localparam logic signed [OP_W-1:0] KP    = OP_W'(KP_Q15);
  localparam logic signed [OP_W-1:0] KITS  = OP_W'(KITS_Q15);

  logic [PH_W-1:0]   phase;
  q15_t              trig [6];     // 0..2 sine a/b/c, 3..5 cosine a/b/c
  q15_t              meas [3], setp [3], vm [3], err [3], u [3], ref_st [3];
  logic signed [IW-1:0]   integ [3];
  logic signed [OP_W-1:0] op_a, op_b;
  logic signed [PR_W-1:0] prod;
  logic signed [AC_W-1:0] prod_x, acc, pterm;
  logic [STEP_W-1:0] step;
  int unsigned       st;
  logic              busy, adv, sq_start, sq_done;
  logic [15:0]       sq_root;

  function automatic logic signed [IW-1:0] clamp_int(input logic signed [AC_W-1:0] x);
    if (x > I_LIM)  return IW'(I_LIM);
    if (x < -I_LIM) return IW'(-I_LIM);
    return x[IW-1:0];
  endfunction

  phase_accum #(.PH_W(PH_W), .STEP(PH_STEP)) u_phase (
    .clk(clk), .rst_n(rst_n), .adv(adv), .phase(phase));

  for (genvar g = 0; g < 6; g++) begin : g_trig
    localparam logic [PH_W-1:0] OFS =
      ((g >= 3) ? PH_QTR : PH_W'(0)) - PH_W'(g % 3) * PH_THIRD;
    sine_quarter_lut #(.IDX_W(LUT_IDX_W)) u_lut (
      .idx(LUT_IDX_W'((phase + OFS) >> (PH_W - LUT_IDX_W))), .val(trig[g]));
  end

  assign st = 32'(step);

  always_comb begin
    for (int k = 0; k < 3; k++) err[k] = sat_q15(AC_W'(setp[k]) - AC_W'(vm[k]));
  end

  // operand routing for the single shared multiplier
  always_comb begin
    op_a = '0;
    op_b = '0;
    if (st <= 2) begin
      op_a = OP_W'(meas[st]); op_b = OP_W'(trig[st]);
    end else if (st == 3 || st == 7) begin
      op_a = OP_W'(rnd_q15(acc)); op_b = K_TWO_THIRDS;
    end else if (st <= 6) begin
      op_a = OP_W'(meas[st-4]); op_b = OP_W'(trig[st-1]);
    end else if (st == 8) begin
      op_a = OP_W'(meas[0]) + OP_W'(meas[1]) + OP_W'(meas[2]);
      op_b = K_ONE_THIRD;
    end else if (st <= 14) begin
      op_a = OP_W'(err[(st-9)/2]);
      op_b = ((st - 9) % 2 == 0) ? KP : KITS;
    end else if (st <= 20) begin
      op_a = ((st - 15) % 2 == 0) ? OP_W'(u[0]) : OP_W'(u[1]);
      op_b = ((st - 15) % 2 == 0) ? OP_W'(trig[(st-15)/2]) : OP_W'(trig[3+(st-15)/2]);
    end else if (st <= S_SQRT) begin
      op_a = OP_W'(u[st-21]); op_b = OP_W'(u[st-21]);
    end
  end

  assign prod     = op_a * op_b;
  assign prod_x   = AC_W'(prod);
  assign sq_start = busy && (st == S_SQRT);
  assign adv      = busy && (st == S_WAIT) && sq_done;

  isqrt_seq #(.RAD_W(32)) u_sqrt (
    .clk(clk), .rst_n(rst_n), .start(sq_start),
    .rad(32'(acc + prod_x)), .done(sq_done), .root(sq_root));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; step <= '0; acc <= '0; pterm <= '0; done <= 1'b0;
      ref_a <= '0; ref_b <= '0; ref_c <= '0; mod_index <= '0;
      for (int k = 0; k < 3; k++) begin
        meas[k] <= '0; setp[k] <= '0; vm[k] <= '0;
        u[k] <= '0; ref_st[k] <= '0; integ[k] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (sample_stb) begin
          busy <= 1'b1;
          step <= '0;
          meas[0] <= ph_a;  meas[1] <= ph_b;  meas[2] <= ph_c;
          setp[0] <= set_d; setp[1] <= set_q; setp[2] <= set_z;
        end
      end else begin
        if (st != S_WAIT) step <= step + 1'b1;
        case (st)
          0, 4, 15, 17, 19, 21: acc <= prod_x;
          1, 2, 5, 6:           acc <= acc + prod_x;
          3:                    vm[0] <= sat_q15(rnd_q15(prod_x));
          7:                    vm[1] <= sat_q15(rnd_q15(prod_x));
          8:                    vm[2] <= sat_q15(rnd_q15(prod_x));
          9, 11, 13:            pterm <= prod_x;
          10, 12, 14: begin
            u[(st-10)/2]     <= sat_q15(rnd_q15(pterm + AC_W'(integ[(st-10)/2])));
            integ[(st-10)/2] <= clamp_int(AC_W'(integ[(st-10)/2]) + prod_x);
          end
          16, 18, 20: ref_st[(st-16)/2] <= sat_q15(rnd_q15(acc + prod_x) + AC_W'(u[2]));
          S_WAIT: if (sq_done) begin
            ref_a <= ref_st[0]; ref_b <= ref_st[1]; ref_c <= ref_st[2];
            mod_index <= sq_root[15] ? 16'sh7fff : $signed(sq_root);
            done <= 1'b1;
            busy <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ref_a) && $stable(ref_b) && $stable(ref_c) && $stable(mod_index));
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(phase));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sample_stb) |=> $stable(meas[0]) && $stable(setp[0]) && $stable(meas[2]));
  for (genvar k = 0; k < 3; k++) begin : g_int_chk
    // R6
    int_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (AC_W'(integ[k]) <= I_LIM) && (AC_W'(integ[k]) >= -I_LIM));
  end
endmodule

// File: tb/dq0_pi_regulator_tb.sv
module dq0_pi_regulator_tb;
  localparam real KP   = 3277.0 / 32768.0;
  localparam real KITS = 33.0 / 32768.0;
  localparam real ILIM = 0.5;
  localparam real QMAX = 32767.0 / 32768.0;
  localparam real TOL  = 0.002;
  localparam real PI2  = 6.283185307179586;
  localparam longint unsigned INC   = 64'd21474836;
  localparam longint unsigned THIRD = 64'd1431655765;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic signed [15:0] ph_a = '0, ph_b = '0, ph_c = '0;
  logic signed [15:0] set_d = '0, set_q = '0, set_z = '0;
  logic signed [15:0] ref_a, ref_b, ref_c, mod_index;
  logic done;

  int n_checks = 0;
  int n_fail = 0;
  int sat_seen = 0;
  longint unsigned nsamp = 0;
  real integ_m [3];
  real last_m;

  always #5 clk = ~clk;

  dq0_pi_regulator u_dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
    .set_d(set_d), .set_q(set_q), .set_z(set_z),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .mod_index(mod_index), .done(done));

  function automatic logic signed [15:0] to_q(input real r);
    int v;
    v = $rtoi(r * 32768.0);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return 16'(v);
  endfunction

  function automatic real satr(input real r);
    if (r > QMAX) return QMAX;
    if (r < -1.0) return -1.0;
    return r;
  endfunction

  function automatic real angle_sin(input logic [31:0] a);
    return $sin(PI2 * real'(a[31:22]) / 1024.0);
  endfunction

  task automatic check_val(input string req, input string what, input int act, input real exp);
    n_checks++;
    if ((real'(act) / 32768.0 - exp) > TOL || (exp - real'(act) / 32768.0) > TOL) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, $rtoi(exp * 32768.0));
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // one regulation step; dbl issues a second strobe while busy
  task automatic run_sample(input real a, b, c, sd, sq, sz, input string req, input bit dbl);
    logic signed [15:0] qa, qb, qc, qd, qq, qz;
    logic [31:0] ph, ang;
    real xs [3], sn [3], cs [3], v [3], e [3], uu [3], raw, m;
    int lat, act [3];
    bit early;
    qa = to_q(a); qb = to_q(b); qc = to_q(c);
    qd = to_q(sd); qq = to_q(sq); qz = to_q(sz);
    @(negedge clk);
    ph_a = qa; ph_b = qb; ph_c = qc; set_d = qd; set_q = qq; set_z = qz;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    act[0] = ref_a; act[1] = ref_b; act[2] = ref_c;
    early = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      if (ref_a != act[0] || ref_b != act[1] || ref_c != act[2]) early = 1'b1;
      if (dbl && lat == 3) begin
        ph_a = -qa; set_d = -qd; sample_stb = 1'b1;
      end else begin
        sample_stb = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    sample_stb = 1'b0;
    check_eq("R9", "latency in window", int'(lat >= 20 && lat <= 64), 1);
    check_eq("R9", "no output change before done", int'(early), 0);
    // model
    ph = 32'(nsamp * INC);
    xs[0] = real'(qa) / 32768.0; xs[1] = real'(qb) / 32768.0; xs[2] = real'(qc) / 32768.0;
    for (int p = 0; p < 3; p++) begin
      ang = ph - 32'(longint'(p) * THIRD);
      sn[p] = angle_sin(ang);
      cs[p] = angle_sin(ang + 32'h4000_0000);
    end
    v[0] = satr(2.0 / 3.0 * (xs[0] * sn[0] + xs[1] * sn[1] + xs[2] * sn[2]));
    v[1] = satr(2.0 / 3.0 * (xs[0] * cs[0] + xs[1] * cs[1] + xs[2] * cs[2]));
    v[2] = satr((xs[0] + xs[1] + xs[2]) / 3.0);
    e[0] = satr(real'(qd) / 32768.0 - v[0]);
    e[1] = satr(real'(qq) / 32768.0 - v[1]);
    e[2] = satr(real'(qz) / 32768.0 - v[2]);
    for (int k = 0; k < 3; k++) begin
      uu[k] = satr(KP * e[k] + integ_m[k]);
      integ_m[k] = integ_m[k] + KITS * e[k];
      if (integ_m[k] > ILIM) integ_m[k] = ILIM;
      if (integ_m[k] < -ILIM) integ_m[k] = -ILIM;
    end
    nsamp++;
    act[0] = ref_a; act[1] = ref_b; act[2] = ref_c;
    for (int p = 0; p < 3; p++) begin
      raw = uu[0] * sn[p] + uu[1] * cs[p] + uu[2];
      check_val({req, " R7"}, "phase reference", act[p], satr(raw));
      if (raw > 1.01) begin
        sat_seen++;
        check_eq("R7", "saturated reference", act[p], 32767);
      end
    end
    m = $sqrt(uu[0] * uu[0] + uu[1] * uu[1]);
    if (m > QMAX) m = QMAX;
    last_m = m;
    check_val("R8", "modulation index", mod_index, m);
    if (dbl) begin
      lat = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (done) lat++;
      end
      check_eq("R10", "extra done pulses", lat, 0);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R1", "ref_a in reset", ref_a, 0);
    check_eq("R1", "mod_index in reset", mod_index, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "done after reset", int'(done), 0);
    check_eq("R1", "ref_c after reset", ref_c, 0);
    nsamp = 0;
    for (int k = 0; k < 3; k++) integ_m[k] = 0.0;
    // first step: angle 0, no integral term: ref_b = 0.05*sin(-120 deg)
    run_sample(0.0, 0.0, 0.0, 0.5, 0.0, 0.0, "R1", 1'b0);
    check_val("R1", "ref_b first step", ref_b, 0.05 * $sin(-PI2 / 3.0));
  endtask

  task automatic t_phase;
    for (int i = 0; i < 15; i++) run_sample(0.0, 0.0, 0.0, 0.5, 0.2, 0.0, "R2", 1'b0);
  endtask

  task automatic t_balanced;
    real th;
    for (int i = 0; i < 40; i++) begin
      th = PI2 * real'(32'(nsamp * INC)) / 4294967296.0;
      run_sample(0.8 * $sin(th), 0.8 * $sin(th - PI2 / 3.0), 0.8 * $sin(th - 2.0 * PI2 / 3.0),
                 0.8, 0.1, 0.0, "R3 R4", 1'b0);
    end
  endtask

  task automatic t_zero_seq;
    for (int i = 0; i < 20; i++) run_sample(0.3, 0.3, 0.3, -0.2, 0.2, 0.1, "R4 R5", 1'b0);
  endtask

  task automatic t_busy;
    run_sample(0.1, -0.4, 0.2, 0.3, -0.3, 0.0, "R10", 1'b1);
    run_sample(0.1, -0.4, 0.2, 0.3, -0.3, 0.0, "R10", 1'b0);
  endtask

  task automatic t_clamp;
    for (int i = 0; i < 620; i++) run_sample(0.0, 0.0, 0.0, 0.9, 0.9, 0.9, "R6", 1'b0);
    check_val("R6", "index with clamped integrators", mod_index, $sqrt(2.0) * (0.5 + KP * 0.9));
    check_eq("R7", "saturation reached", int'(sat_seen > 0), 1);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) integ_m[k] = 0.0;
    t_reset();
    t_phase();
    t_balanced();
    t_zero_seq();
    t_busy();
    t_clamp();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule